// File: doc/BRIEF.md
# Dual Channel-Selected Symmetric FIR Filter

This block sits behind an ADC result stream in which every converted value carries a channel tag. It holds two independent FIR filters. Each filter picks one channel out of the stream, keeps a history of that channel's recent results and produces one filtered value for each result it takes in. The filter ignores every other result, so its history moves forward only when its own channel reports.

The coefficient set is mirror-symmetric around the centre of the active tap window. Only the first half of the coefficients is stored. Before multiplication, the two samples that share a coefficient are added together. The active tap count can be set anywhere from 1 to 16. When the count is odd, the centre sample is multiplied alone. A warm-up option holds back outputs until the history is completely filled with real samples.

Each filter moves between three named states. OFF means the filter is disabled and its history is kept at zero. FILL means the filter is enabled and fewer than 16 samples have been taken since the last clear. FULL means at least 16 samples have been taken since the last clear. The transitions are as follows:
- Enable takes OFF to FILL, or to FULL when that single sample already completes the history.
- The sixteenth accepted sample takes FILL to FULL.
- A channel re-selection takes FULL back to FILL. It takes FILL to FILL and restarts the count.
- Disable takes FILL or FULL to OFF.

Configuration arrives through a small write-only register port. Address bit 4 selects the instance. Sub-addresses 0 to 7 hold the eight stored coefficients. Sub-address 8 holds the control word.

Top module: `symfir_dual`

## Requirements
- R1: A filter accepts a result only when in_valid is high, the filter is enabled and in_chan equals its selected channel. Any other result leaves its output strobe low and does not change its history.
- R2: For an accepted sample the output is the sum over j < N of c[j]·x[j]. Here x[0] is the newest accepted sample and x[j] is the sample accepted j steps earlier. The coefficient c[j] is the stored coefficient at sub-address min(j, N-1-j).
- R3: The tap count N equals the control field at bits [10:7] plus one, so N ranges from 1 to 16. When N is odd, the centre sample is weighted once by its own coefficient.
- R4: out_valid for an instance is high for exactly the one cycle after the edge that accepted the sample. out_data holds the value it produced.
- R5: With the warm-up bit set (control bit 1), no output is valid until 16 samples have been accepted since the last clear. The sixteenth sample produces the first valid output.
- R6: With the warm-up bit clear, every accepted sample produces a valid output. History positions never filled since the last clear count as zero.
- R7: Clearing the enable bit (control bit 0) empties the history and the sample count. A filter that is enabled again starts as if it had just been reset.
- R8: Changing the selected channel (control bits [6:2]) empties the history and the sample count. A sample on the new channel in the first cycle the new selection is active becomes the newest and only sample.
- R9: A write with address bit 4 equal to i reaches only instance i. The other instance's settings and output stream are unchanged.
- R10: Sixteen taps of coefficient -32768 applied to sixteen samples of -32768 give exactly +2^34 on the 36-bit signed output, with no wrap.
- R11: After reset both instances are disabled, all coefficients are zero, out_valid is low and out_data is zero.
- R12: A register write takes effect at the clock edge that captures it. A sample presented in the same cycle as the write is processed with the settings from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | 5 | Bit 4 is the instance; bits 3:0 are the sub-address (0-7 coefficient, 8 control) |
| cfg_wdata | input | 16 | Write data: a signed coefficient or the control word |
| in_valid | input | 1 | A tagged ADC result is present |
| in_chan | input | 5 | Channel tag of the result |
| in_data | input | 16 | Signed result value |
| out_valid | output | 2 | Per-instance output strobe |
| out_data | output | 72 | Per-instance 36-bit signed sum; instance i occupies bits [36i+35:36i] |

## Verification
Two operations can land in the same cycle: a write that changes the selected channel, and the arrival of a sample. The bench provokes this in two ways. First, it presents a sample on the old channel in the same cycle as the write, so that sample must still be filtered with the old settings. Second, it presents a sample on the new channel in the very next cycle, so the clear of the history and the intake of the first new sample must happen in one step. A coefficient write that lands together with a sample is also provoked. The behavioural model in the bench advances its queues only after each edge's inputs have been applied, and every output is compared against it on every clock.

// File: rtl/symfir_pkg.sv
package symfir_pkg;

    localparam int ST_W = 2;

    typedef enum logic [ST_W-1:0] {
        ST_OFF  = 2'd0,
        ST_FILL = 2'd1,
        ST_FULL = 2'd2
    } fir_state_e;

    localparam int CTRL_EN_BIT   = 0;
    localparam int CTRL_WAIT_BIT = 1;
    localparam int CTRL_CH_LSB   = 2;

endpackage

// File: rtl/symfir_regs.sv
module symfir_regs
    import symfir_pkg::*;
#(
    parameter int COEF_W   = 16,
    parameter int CH_W     = 5,
    parameter int TAP_W    = 4,
    parameter int NUM_COEF = 8,
    parameter int SUB_W    = 4,
    parameter int INST_W   = 1,
    parameter int INST_ID  = 0
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [INST_W+SUB_W-1:0]  wr_addr,
    input  logic [COEF_W-1:0]        wr_data,
    output logic                     en,
    output logic                     wait_mode,
    output logic [CH_W-1:0]          chan,
    output logic [TAP_W-1:0]         ntap_m1,
    output logic signed [COEF_W-1:0] coef [NUM_COEF]
);

    localparam int ADDR_W   = INST_W + SUB_W;
    localparam int TAP_LSB  = CTRL_CH_LSB + CH_W;
    localparam logic [SUB_W-1:0] CTRL_SUB = SUB_W'(NUM_COEF);

    logic             hit;
    logic [SUB_W-1:0] sub;

    assign hit = wr_en && (wr_addr[ADDR_W-1:SUB_W] == INST_W'(INST_ID));
    assign sub = wr_addr[SUB_W-1:0];

    for (genvar k = 0; k < NUM_COEF; k++) begin : g_coef
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                coef[k] <= '0;
            end else if (hit && (sub == SUB_W'(k))) begin
                coef[k] <= wr_data;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en        <= 1'b0;
            wait_mode <= 1'b0;
            chan      <= '0;
            ntap_m1   <= '0;
        end else if (hit && (sub == CTRL_SUB)) begin
            en        <= wr_data[CTRL_EN_BIT];
            wait_mode <= wr_data[CTRL_WAIT_BIT];
            chan      <= wr_data[CTRL_CH_LSB +: CH_W];
            ntap_m1   <= wr_data[TAP_LSB +: TAP_W];
        end
    end

endmodule

// File: rtl/symfir_mac.sv
module symfir_mac #(
    parameter int DATA_W   = 16,
    parameter int COEF_W   = 16,
    parameter int MAX_TAPS = 16,
    parameter int TAP_W    = 4,
    parameter int ACC_W    = 36,
    parameter int NUM_COEF = MAX_TAPS / 2
) (
    input  logic signed [DATA_W-1:0] win [MAX_TAPS],
    input  logic [TAP_W-1:0]         ntap_m1,
    input  logic signed [COEF_W-1:0] coef [NUM_COEF],
    output logic signed [ACC_W-1:0]  acc
);

    localparam int PRE_W  = DATA_W + 1;
    localparam int PROD_W = PRE_W + COEF_W;

    logic signed [PROD_W-1:0] prod [NUM_COEF];

    for (genvar k = 0; k < NUM_COEF; k++) begin : g_pair
        logic [TAP_W:0]           diff;
        logic [TAP_W-1:0]         mir;
        logic                     use_pair;
        logic                     use_mid;
        logic signed [PRE_W-1:0]  pre;

        assign diff     = {1'b0, ntap_m1} - (TAP_W+1)'(k);
        assign mir      = diff[TAP_W-1:0];
        assign use_pair = !diff[TAP_W] && (mir > TAP_W'(k));
        assign use_mid  = !diff[TAP_W] && (mir == TAP_W'(k));

        always_comb begin
            if (use_pair) begin
                pre = PRE_W'(win[k]) + PRE_W'(win[mir]);
            end else if (use_mid) begin
                pre = PRE_W'(win[k]);
            end else begin
                pre = '0;
            end
        end

        assign prod[k] = pre * coef[k];
    end

    always_comb begin
        acc = '0;
        for (int k = 0; k < NUM_COEF; k++) begin
            acc = acc + ACC_W'(prod[k]);
        end
    end

endmodule

// File: rtl/symfir_core.sv
module symfir_core
    import symfir_pkg::*;
#(
    parameter int DATA_W   = 16,
    parameter int COEF_W   = 16,
    parameter int CH_W     = 5,
    parameter int MAX_TAPS = 16,
    parameter int TAP_W    = 4,
    parameter int ACC_W    = 36,
    parameter int NUM_COEF = MAX_TAPS / 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    input  logic [CH_W-1:0]          in_chan,
    input  logic signed [DATA_W-1:0] in_data,
    input  logic                     en,
    input  logic                     wait_mode,
    input  logic [CH_W-1:0]          chan,
    input  logic [TAP_W-1:0]         ntap_m1,
    input  logic signed [COEF_W-1:0] coef [NUM_COEF],
    output logic                     out_valid,
    output logic signed [ACC_W-1:0]  out_data,
    output fir_state_e               state
);

    localparam int DL_DEPTH = MAX_TAPS - 1;
    localparam int CNT_W    = $clog2(MAX_TAPS + 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(MAX_TAPS);

    fir_state_e               state_n;
    logic signed [DATA_W-1:0] dl_q    [DL_DEPTH];
    logic signed [DATA_W-1:0] base_dl [DL_DEPTH];
    logic signed [DATA_W-1:0] win     [MAX_TAPS];
    logic [CNT_W-1:0]         cnt_q;
    logic [CNT_W-1:0]         base_cnt;
    logic [CNT_W-1:0]         cnt_inc;
    logic [CH_W-1:0]          chan_seen_q;
    logic                     restart;
    logic                     clr;
    logic                     accept;
    logic                     full_after;
    logic                     gate;
    logic signed [ACC_W-1:0]  acc;

    // Clear and intake decisions for this cycle
    always_comb begin
        restart    = en && (chan != chan_seen_q);
        clr        = !en || restart || (state == ST_OFF);
        accept     = en && in_valid && (in_chan == chan);
        base_cnt   = clr ? '0 : cnt_q;
        cnt_inc    = (base_cnt == CNT_FULL) ? CNT_FULL : base_cnt + 1'b1;
        full_after = (cnt_inc == CNT_FULL);
        gate       = !wait_mode || full_after;
        for (int j = 0; j < DL_DEPTH; j++) begin
            base_dl[j] = clr ? '0 : dl_q[j];
        end
    end

    // Window seen by the multiply stage: newest sample first
    always_comb begin
        win[0] = in_data;
        for (int j = 1; j < MAX_TAPS; j++) begin
            win[j] = base_dl[j-1];
        end
    end

    symfir_mac #(
        .DATA_W  (DATA_W),
        .COEF_W  (COEF_W),
        .MAX_TAPS(MAX_TAPS),
        .TAP_W   (TAP_W),
        .ACC_W   (ACC_W),
        .NUM_COEF(NUM_COEF)
    ) u_mac (
        .win    (win),
        .ntap_m1(ntap_m1),
        .coef   (coef),
        .acc    (acc)
    );

    always_comb begin
        state_n = state;
        unique case (state)
            ST_OFF: begin
                if (en) begin
                    state_n = (accept && full_after) ? ST_FULL : ST_FILL;
                end
            end
            ST_FILL: begin
                if (!en) begin
                    state_n = ST_OFF;
                end else if (accept && full_after) begin
                    state_n = ST_FULL;
                end
            end
            ST_FULL: begin
                if (!en) begin
                    state_n = ST_OFF;
                end else if (restart) begin
                    state_n = (accept && full_after) ? ST_FULL : ST_FILL;
                end
            end
            default: state_n = ST_OFF;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_OFF;
        end else begin
            state <= state_n;
        end
    end

    // History and sample count
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int j = 0; j < DL_DEPTH; j++) begin
                dl_q[j] <= '0;
            end
            cnt_q       <= '0;
            chan_seen_q <= '0;
        end else begin
            chan_seen_q <= chan;
            if (accept) begin
                dl_q[0] <= in_data;
                for (int j = 1; j < DL_DEPTH; j++) begin
                    dl_q[j] <= base_dl[j-1];
                end
                cnt_q <= cnt_inc;
            end else begin
                dl_q  <= base_dl;
                cnt_q <= base_cnt;
            end
        end
    end

    // Outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= accept && gate;
            if (accept) begin
                out_data <= acc;
            end
        end
    end

endmodule

// File: rtl/symfir_dual.sv
module symfir_dual
    import symfir_pkg::*;
#(
    parameter int NUM_INST = 2,
    parameter int DATA_W   = 16,
    parameter int COEF_W   = 16,
    parameter int CH_W     = 5,
    parameter int MAX_TAPS = 16,
    parameter int INST_W   = (NUM_INST > 1) ? $clog2(NUM_INST) : 1,
    parameter int SUB_W    = $clog2(MAX_TAPS / 2 + 1),
    parameter int ACC_W    = DATA_W + COEF_W + $clog2(MAX_TAPS)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      cfg_wr,
    input  logic [INST_W+SUB_W-1:0]   cfg_addr,
    input  logic [COEF_W-1:0]         cfg_wdata,
    input  logic                      in_valid,
    input  logic [CH_W-1:0]           in_chan,
    input  logic [DATA_W-1:0]         in_data,
    output logic [NUM_INST-1:0]       out_valid,
    output logic [NUM_INST*ACC_W-1:0] out_data
);

    localparam int TAP_W    = $clog2(MAX_TAPS);
    localparam int NUM_COEF = MAX_TAPS / 2;

    logic [NUM_INST-1:0]      en_vec;
    logic [NUM_INST-1:0]      wait_vec;
    logic [NUM_INST*CH_W-1:0] chan_vec;
    logic [NUM_INST*ST_W-1:0] state_vec;

    for (genvar i = 0; i < NUM_INST; i++) begin : g_inst
        logic                     en_i;
        logic                     wait_i;
        logic [CH_W-1:0]          chan_i;
        logic [TAP_W-1:0]         ntap_i;
        logic signed [COEF_W-1:0] coef_i [NUM_COEF];
        fir_state_e               st_i;
        logic                     v_i;
        logic signed [ACC_W-1:0]  d_i;

        symfir_regs #(
            .COEF_W  (COEF_W),
            .CH_W    (CH_W),
            .TAP_W   (TAP_W),
            .NUM_COEF(NUM_COEF),
            .SUB_W   (SUB_W),
            .INST_W  (INST_W),
            .INST_ID (i)
        ) u_regs (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_en    (cfg_wr),
            .wr_addr  (cfg_addr),
            .wr_data  (cfg_wdata),
            .en       (en_i),
            .wait_mode(wait_i),
            .chan     (chan_i),
            .ntap_m1  (ntap_i),
            .coef     (coef_i)
        );

        symfir_core #(
            .DATA_W  (DATA_W),
            .COEF_W  (COEF_W),
            .CH_W    (CH_W),
            .MAX_TAPS(MAX_TAPS),
            .TAP_W   (TAP_W),
            .ACC_W   (ACC_W),
            .NUM_COEF(NUM_COEF)
        ) u_core (
            .clk      (clk),
            .rst_n    (rst_n),
            .in_valid (in_valid),
            .in_chan  (in_chan),
            .in_data  (in_data),
            .en       (en_i),
            .wait_mode(wait_i),
            .chan     (chan_i),
            .ntap_m1  (ntap_i),
            .coef     (coef_i),
            .out_valid(v_i),
            .out_data (d_i),
            .state    (st_i)
        );

        assign out_valid[i]                = v_i;
        assign out_data[i*ACC_W +: ACC_W]  = d_i;
        assign en_vec[i]                   = en_i;
        assign wait_vec[i]                 = wait_i;
        assign chan_vec[i*CH_W +: CH_W]    = chan_i;
        assign state_vec[i*ST_W +: ST_W]   = st_i;
    end

endmodule

// File: rtl/symfir_dual_chk.sv
module symfir_dual_chk
    import symfir_pkg::*;
#(
    parameter int NUM_INST = 2,
    parameter int CH_W     = 5,
    parameter int INST_W   = 1,
    parameter int SUB_W    = 4
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      cfg_wr,
    input logic [INST_W+SUB_W-1:0]   cfg_addr,
    input logic                      in_valid,
    input logic [CH_W-1:0]           in_chan,
    input logic [NUM_INST-1:0]       out_valid,
    input logic [NUM_INST-1:0]       en_vec,
    input logic [NUM_INST-1:0]       wait_vec,
    input logic [NUM_INST*CH_W-1:0]  chan_vec,
    input logic [NUM_INST*ST_W-1:0]  state_vec
);

    localparam int ADDR_W = INST_W + SUB_W;

    for (genvar i = 0; i < NUM_INST; i++) begin : g_chk
        // R1
        chan_filter_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && (in_chan != chan_vec[i*CH_W +: CH_W])) |=> !out_valid[i]);

        // R4
        latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid[i] |-> ($past(in_valid) && $past(en_vec[i])
                              && ($past(in_chan) == $past(chan_vec[i*CH_W +: CH_W]))));

        // R7
        disable_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !en_vec[i] |=> (!out_valid[i] && (state_vec[i*ST_W +: ST_W] == ST_W'(ST_OFF))));

        // R5
        warmup_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (out_valid[i] && $past(wait_vec[i])) |-> (state_vec[i*ST_W +: ST_W] == ST_W'(ST_FULL)));

        // R9
        inst_isolation_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (cfg_wr && (cfg_addr[ADDR_W-1:SUB_W] != INST_W'(i)))
            |=> ($stable(en_vec[i]) && $stable(wait_vec[i]) && $stable(chan_vec[i*CH_W +: CH_W])));
    end

endmodule

bind symfir_dual symfir_dual_chk #(
    .NUM_INST(NUM_INST),
    .CH_W    (CH_W),
    .INST_W  (INST_W),
    .SUB_W   (SUB_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_wr   (cfg_wr),
    .cfg_addr (cfg_addr),
    .in_valid (in_valid),
    .in_chan  (in_chan),
    .out_valid(out_valid),
    .en_vec   (en_vec),
    .wait_vec (wait_vec),
    .chan_vec (chan_vec),
    .state_vec(state_vec)
);

// File: tb/test_symfir_dual.sv
module test_symfir_dual;

    localparam int ACC_W = 36;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        b_wr = 1'b0;
    logic [4:0]  b_addr = '0;
    logic [15:0] b_wd = '0;
    logic        b_iv = 1'b0;
    logic [4:0]  b_ich = '0;
    logic [15:0] b_id = '0;
    logic [1:0]  out_valid;
    logic [71:0] out_data;

    always #4 clk = ~clk;

    symfir_dual i_symfir_dual (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_wr   (b_wr),
        .cfg_addr (b_addr),
        .cfg_wdata(b_wd),
        .in_valid (b_iv),
        .in_chan  (b_ich),
        .in_data  (b_id),
        .out_valid(out_valid),
        .out_data (out_data)
    );

    int     n_cmp = 0;
    int     n_bad = 0;
    bit     done  = 0;
    string  req   = "R11";

    int     m_en [2], m_wt [2], m_ch [2], m_n [2], m_seen [2], m_cnt [2];
    longint m_coef [2][8];
    longint m_hist [2][$];
    bit     exp_v [2];
    longint exp_d [2];

    function automatic int ctrlw(int en, int wt, int ch, int n);
        return en | (wt << 1) | (ch << 2) | ((n - 1) << 7);
    endfunction

    task automatic model_reset();
        for (int i = 0; i < 2; i++) begin
            m_en[i] = 0; m_wt[i] = 0; m_ch[i] = 0; m_n[i] = 1;
            m_seen[i] = 0; m_cnt[i] = 0; exp_v[i] = 0; exp_d[i] = 0;
            m_hist[i].delete();
            for (int k = 0; k < 8; k++) m_coef[i][k] = 0;
        end
    endtask

    // Applies what the design sees at one rising edge
    task automatic model_step();
        for (int i = 0; i < 2; i++) begin
            if (!m_en[i] || (m_ch[i] != m_seen[i])) begin
                m_hist[i].delete();
                m_cnt[i] = 0;
            end
            exp_v[i] = 0;
            if (m_en[i] != 0 && b_iv && (int'(b_ich) == m_ch[i])) begin
                longint s = 0;
                m_hist[i].push_front(longint'($signed(b_id)));
                if (m_hist[i].size() > 16) void'(m_hist[i].pop_back());
                if (m_cnt[i] < 16) m_cnt[i]++;
                for (int j = 0; j < m_n[i]; j++) begin
                    int     k = (j < m_n[i] - 1 - j) ? j : m_n[i] - 1 - j;
                    longint x = (j < m_hist[i].size()) ? m_hist[i][j] : 0;
                    s += m_coef[i][k] * x;
                end
                exp_v[i] = (m_wt[i] == 0) || (m_cnt[i] >= 16);
                exp_d[i] = s;
            end
            m_seen[i] = m_ch[i];
        end
        if (b_wr) begin
            int inst = int'(b_addr[4]);
            int sub  = int'(b_addr[3:0]);
            if (sub < 8) begin
                m_coef[inst][sub] = longint'($signed(b_wd));
            end else if (sub == 8) begin
                m_en[inst] = int'(b_wd[0]);
                m_wt[inst] = int'(b_wd[1]);
                m_ch[inst] = int'(b_wd[6:2]);
                m_n[inst]  = int'(b_wd[10:7]) + 1;
            end
        end
    endtask

    task automatic compare();
        for (int i = 0; i < 2; i++) begin
            n_cmp++;
            if (out_valid[i] !== exp_v[i]) begin
                n_bad++;
                $display("FAIL %s inst%0d out_valid actual=%0b expected=%0b", req, i, out_valid[i], exp_v[i]);
            end
            if (exp_v[i]) begin
                longint act = longint'($signed(out_data[i*ACC_W +: ACC_W]));
                n_cmp++;
                if (act != exp_d[i]) begin
                    n_bad++;
                    $display("FAIL %s inst%0d out_data actual=%0d expected=%0d", req, i, act, exp_d[i]);
                end
            end
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        model_step();
        @(negedge clk);
        compare();
        b_wr = 1'b0;
        b_iv = 1'b0;
    endtask

    task automatic wr(int inst, int sub, int data);
        b_wr = 1'b1; b_addr = 5'(inst * 16 + sub); b_wd = 16'(data);
        cyc();
    endtask

    task automatic smp(int ch, int d);
        b_iv = 1'b1; b_ich = 5'(ch); b_id = 16'(d);
        cyc();
    endtask

    task automatic idle(int n);
        for (int k = 0; k < n; k++) cyc();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        // R11: outputs quiet during reset
        n_cmp++;
        if (out_valid !== 2'b00 || out_data !== '0) begin
            n_bad++;
            $display("FAIL R11 reset outputs actual=%0b/%0h expected=0/0", out_valid, out_data);
        end
        rst_n = 1'b1;
        idle(2);

        // R11 R1: disabled filters ignore traffic
        req = "R11 R1";
        smp(0, 100); smp(3, 200);

        // R9 R12: program both instances
        req = "R9 R12";
        begin
            int c0 [8] = '{3, -5, 7, 2, -1, 4, 6, -8};
            int c1 [8] = '{10, 20, -30, 40, 5, 6, 7, 8};
            for (int k = 0; k < 8; k++) wr(0, k, c0[k]);
            for (int k = 0; k < 8; k++) wr(1, k, c1[k]);
        end
        wr(0, 8, ctrlw(1, 1, 3, 16));
        wr(1, 8, ctrlw(1, 0, 7, 5));

        // R5 R6 R1 R4: mixed stream, instance 0 warming up
        req = "R5 R6 R1 R4";
        for (int k = 0; k < 60; k++) begin
            int pick = int'($urandom_range(0, 2));
            int ch = (pick == 0) ? 3 : ((pick == 1) ? 7 : 2);
            smp(ch, int'($urandom_range(0, 65535)));
            if (k % 5 == 4) idle(1);
        end

        // R2 R3 R6: sweep tap counts, even and odd
        req = "R2 R3 R6";
        begin
            int nl [6] = '{1, 2, 7, 15, 16, 8};
            for (int t = 0; t < 6; t++) begin
                wr(0, 8, ctrlw(1, 0, 3, nl[t]));
                wr(1, 8, ctrlw(1, 0, 7, 17 - nl[t]));
                for (int k = 0; k < 20; k++) begin
                    smp((k % 2 == 0) ? 3 : 7, int'($urandom_range(0, 65535)));
                end
            end
        end

        // R8 R12: channel change with samples in the write cycle and the next cycle
        req = "R8 R12";
        b_iv = 1'b1; b_ich = 5'd3; b_id = 16'd1234;
        wr(0, 8, ctrlw(1, 0, 9, 16));
        smp(9, 777);
        smp(3, 55);
        for (int k = 0; k < 5; k++) smp(9, 40 * k - 90);

        // R12: coefficient write landing with a sample
        req = "R12";
        b_iv = 1'b1; b_ich = 5'd9; b_id = 16'd500;
        wr(0, 0, -20);
        smp(9, 501);

        // R7 R5: disable, traffic ignored, re-enable with warm-up
        req = "R7 R5";
        wr(1, 8, ctrlw(0, 0, 7, 5));
        smp(7, 11); smp(7, 12);
        wr(1, 8, ctrlw(1, 1, 7, 5));
        for (int k = 0; k < 18; k++) smp(7, k * 3 + 1);

        // R9: instance 1 writes leave instance 0 running unchanged
        req = "R9";
        wr(1, 2, 99);
        for (int k = 0; k < 6; k++) smp((k % 2 == 0) ? 9 : 7, 300 + k);

        // R10: full-scale products over 16 taps
        req = "R10";
        for (int k = 0; k < 8; k++) wr(0, k, 16'h8000);
        wr(0, 8, ctrlw(1, 0, 3, 16));
        for (int k = 0; k < 16; k++) smp(3, 16'h8000);
        n_cmp++;
        if (out_data[35:0] !== 36'h4_0000_0000 || out_valid[0] !== 1'b1) begin
            n_bad++;
            $display("FAIL R10 full-scale actual=%0h expected=400000000", out_data[35:0]);
        end
        idle(2);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule